// File: doc/BRIEF.md
# Z80 Bus Master Controller

This block lets a host-side agent borrow the system bus of a Z80 CPU and run memory cycles on it. The host sends one command at a time on a simple valid/opcode port. The commands are: take the bus, give it back, write one byte, read one byte, fill a range with a constant, stream a block of bytes, set the CPU reset line to a level, or pulse that line low for a counted number of clocks. The controller runs the bus-request/acknowledge handshake with the CPU. It drives the 19-bit address and the 8-bit data bus, and it sequences the active-low memory-request, read and write strobes one clock per step.

Address bits 7 and 14 to 18 have no external buffer, so they are driven only while the bus is owned. All other address bits stay driven at all times. Fills and block writes keep memory-request low for the whole transfer and pulse write once per byte. The acknowledge input goes through a two-flop synchronizer before any logic sees it.

Top module: `zbus_master`

## Requirements
- R1: After reset, busreq_n, mreq_n, rd_n, wr_n and cpu_rst_n are high, data_oe is low, busy, err, rd_valid and bus_owned are low, and addr_oe has bits 7 and 14..18 clear with all other bits set.
- R2: Opcode 0 (acquire) drives busreq_n low in the first cycle after acceptance. bus_owned and busy change only after busack_n has been low through two synchronizer flops, which is 6 busy cycles when the CPU answers 3 clocks after the request. Once the bus is owned, addr_oe is all ones.
- R3: Opcode 1 (release) clears bus_owned and data_oe, clears addr_oe bits 7 and 14..18, and drives busreq_n high, all in the first cycle after acceptance. busy then stays high until the synchronized busack_n reads high.
- R4: Opcode 2 (write) gives, in the cycles after acceptance: address and data driven with data_oe and mreq_n low; then wr_n low; then wr_n high with mreq_n still low; then idle with mreq_n high and data_oe low.
- R5: Opcode 3 (read) gives: address with mreq_n low and data_oe low; then two cycles with rd_n low; then rd_n high with mreq_n low and rd_valid high for exactly that one cycle. rd_data holds data_i as it was at the end of the second rd_n-low cycle. Idle follows.
- R6: Opcode 4 (fill, cmd_len bytes) keeps mreq_n low and data_oe high for the whole transfer. For each byte it spends one cycle with wr_n high and one with wr_n low, writes the same cmd_data each time, and adds one to the address per byte. It ends with one cycle of wr_n high and mreq_n low.
- R7: Opcode 5 (block, cmd_len bytes) uses the same timing as R6. Each byte comes from blk_data, which the controller latches on every clock edge where blk_take is high; blk_take is high exactly cmd_len times.
- R8: Opcodes 2..5 issued while the bus is not owned, and fill or block with cmd_len of 0, raise err for one cycle, do not set busy, and cause no strobe or data-driver activity.
- R9: A command presented while busy is high is ignored, and the running sequence keeps its timing.
- R10: Opcode 6 sets cpu_rst_n to cmd_data[0] from the next cycle on, without raising busy.
- R11: Opcode 7 drives cpu_rst_n low for exactly cmd_len cycles, or 48 cycles when cmd_len is 0, then high again. busy stays high until the pulse has ended.
- R12: rd_n and wr_n are never low together, neither is low while mreq_n is high, and data_oe is low whenever rd_n is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present; taken only while busy is low |
| cmd_op | input | 3 | Opcode 0..7 as listed in the requirements |
| cmd_addr | input | 19 | Start address for memory commands |
| cmd_data | input | 8 | Write or fill byte; bit 0 is the reset level for opcode 6 |
| cmd_len | input | 16 | Byte count for fill and block; tick count for the reset pulse |
| busy | output | 1 | A handshake, memory sequence or pulse is in progress |
| err | output | 1 | One-cycle flag for a rejected command |
| rd_valid | output | 1 | One-cycle strobe for rd_data |
| rd_data | output | 8 | Byte captured by the last read |
| blk_take | output | 1 | blk_data is latched at this clock edge |
| blk_data | input | 8 | Streamed byte for block writes |
| bus_owned | output | 1 | Bus has been granted to the controller |
| busreq_n | output | 1 | Bus request to the CPU, active low |
| busack_n | input | 1 | Bus acknowledge from the CPU, active low, asynchronous |
| addr_o | output | 19 | Address bus value |
| addr_oe | output | 19 | Per-bit address driver enable |
| data_o | output | 8 | Data bus value when driving |
| data_i | input | 8 | Data bus value when reading |
| data_oe | output | 1 | Data bus driver enable |
| mreq_n | output | 1 | Memory request, active low |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| cpu_rst_n | output | 1 | CPU reset line |

## Verification
Some rules hold on every cycle and are checked by the assertions. Read and write strobes never overlap. Strobes only appear inside memory-request. The data drivers are off during a read. No memory request appears without ownership. Ownership implies an active bus request, and the acknowledge has to be seen two cycles before ownership rises. The read strobe and the error flag are single-cycle pulses.

Other behaviour depends on ordering and can only be shown by the bench scenarios. These are the exact per-cycle strobe sequences of write, read, fill and block, address incrementing, which byte a read captures, and how many block bytes are taken. The same goes for the handshake latency, the reset pulse length including its default, and commands that are dropped while the block is busy.

// File: rtl/zbm_pkg.sv
package zbm_pkg;

    typedef enum logic [2:0] {
        OP_ACQUIRE   = 3'd0,
        OP_RELEASE   = 3'd1,
        OP_WRITE     = 3'd2,
        OP_READ      = 3'd3,
        OP_FILL      = 3'd4,
        OP_BLOCK     = 3'd5,
        OP_RST_LEVEL = 3'd6,
        OP_RST_PULSE = 3'd7
    } op_e;

    typedef enum logic [3:0] {
        ST_IDLE, ST_ACQ, ST_REL,
        ST_WSET, ST_WSTB, ST_WHLD,
        ST_RSET, ST_RSTB1, ST_RSTB2, ST_RHLD,
        ST_BSET, ST_BSTB, ST_BEND,
        ST_PULSE
    } st_e;

    typedef struct packed {
        logic mreq_n;
        logic rd_n;
        logic wr_n;
        logic data_oe;
    } strobes_t;

    function automatic logic op_uses_bus(op_e op);
        return (op == OP_WRITE) || (op == OP_READ) ||
               (op == OP_FILL)  || (op == OP_BLOCK);
    endfunction

    function automatic strobes_t strobes_of(st_e s);
        strobes_t r;
        r.mreq_n  = 1'b1;
        r.rd_n    = 1'b1;
        r.wr_n    = 1'b1;
        r.data_oe = 1'b0;
        case (s)
            ST_WSET, ST_WHLD, ST_BSET, ST_BEND: begin
                r.mreq_n  = 1'b0;
                r.data_oe = 1'b1;
            end
            ST_WSTB, ST_BSTB: begin
                r.mreq_n  = 1'b0;
                r.wr_n    = 1'b0;
                r.data_oe = 1'b1;
            end
            ST_RSET, ST_RHLD: r.mreq_n = 1'b0;
            ST_RSTB1, ST_RSTB2: begin
                r.mreq_n = 1'b0;
                r.rd_n   = 1'b0;
            end
            default: ;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/zbm_sync.sv
module zbm_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RESET_VAL}};
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/zbm_rst_pulse.sv
module zbm_rst_pulse #(
    parameter int TICK_W     = 16,
    parameter int DEF_TICKS  = 48
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              set_level,
    input  logic              level,
    input  logic              start,
    input  logic [TICK_W-1:0] ticks,
    output logic              cpu_rst_n,
    output logic              active
);
    localparam logic [TICK_W-1:0] DEF_LOAD = TICK_W'(DEF_TICKS - 1);

    logic [TICK_W-1:0] remaining;

    always_ff @(posedge clk) begin
        if (rst) begin
            cpu_rst_n <= 1'b1;
            remaining <= '0;
            active    <= 1'b0;
        end else if (start) begin
            cpu_rst_n <= 1'b0;
            remaining <= (ticks == '0) ? DEF_LOAD : ticks - 1'b1;
            active    <= 1'b1;
        end else if (set_level) begin
            cpu_rst_n <= level;
            active    <= 1'b0;
        end else if (active) begin
            if (remaining == '0) begin
                cpu_rst_n <= 1'b1;
                active    <= 1'b0;
            end else begin
                remaining <= remaining - 1'b1;
            end
        end
    end
endmodule

// File: rtl/zbm_seq.sv
module zbm_seq
    import zbm_pkg::*;
#(
    parameter int ADDR_W = 19,
    parameter int DATA_W = 8,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  op_e               cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic [LEN_W-1:0]  cmd_len,
    input  logic [DATA_W-1:0] data_i,
    input  logic [DATA_W-1:0] blk_data,
    input  logic              ack_seen_n,
    input  logic              pulse_active,
    output strobes_t          strb,
    output logic              busreq_n,
    output logic              owned,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] data_q,
    output logic              busy,
    output logic              err,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              blk_take,
    output logic              pulse_start,
    output logic              level_set,
    output logic              level_val
);
    st_e              state;
    logic [LEN_W-1:0] remain;
    logic             is_blk;
    logic             accept;
    logic             bad;
    logic             more;

    assign accept = cmd_valid && (state == ST_IDLE);
    assign bad    = op_uses_bus(cmd_op) &&
                    (!owned || (((cmd_op == OP_FILL) || (cmd_op == OP_BLOCK)) &&
                                (cmd_len == '0)));
    assign more   = remain > LEN_W'(1);

    assign busy        = (state != ST_IDLE);
    assign strb        = strobes_of(state);
    assign pulse_start = accept && (cmd_op == OP_RST_PULSE);
    assign level_set   = accept && (cmd_op == OP_RST_LEVEL);
    assign level_val   = cmd_data[0];
    assign blk_take    = (accept && (cmd_op == OP_BLOCK) && !bad) ||
                         ((state == ST_BSTB) && is_blk && more);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            owned    <= 1'b0;
            busreq_n <= 1'b1;
            err      <= 1'b0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
            addr_q   <= '0;
            data_q   <= '0;
            remain   <= '0;
            is_blk   <= 1'b0;
        end else begin
            err      <= 1'b0;
            rd_valid <= 1'b0;
            case (state)
                ST_IDLE: if (accept) begin
                    case (cmd_op)
                        OP_ACQUIRE: begin
                            busreq_n <= 1'b0;
                            state    <= ST_ACQ;
                        end
                        OP_RELEASE: begin
                            owned    <= 1'b0;
                            busreq_n <= 1'b1;
                            state    <= ST_REL;
                        end
                        OP_RST_LEVEL: ;
                        OP_RST_PULSE: state <= ST_PULSE;
                        default: begin
                            if (bad) begin
                                err <= 1'b1;
                            end else begin
                                addr_q <= cmd_addr;
                                remain <= cmd_len;
                                is_blk <= (cmd_op == OP_BLOCK);
                                data_q <= (cmd_op == OP_BLOCK) ? blk_data : cmd_data;
                                case (cmd_op)
                                    OP_WRITE: state <= ST_WSET;
                                    OP_READ:  state <= ST_RSET;
                                    default:  state <= ST_BSET;
                                endcase
                            end
                        end
                    endcase
                end
                ST_ACQ: if (!ack_seen_n) begin
                    owned <= 1'b1;
                    state <= ST_IDLE;
                end
                ST_REL:   if (ack_seen_n) state <= ST_IDLE;
                ST_WSET:  state <= ST_WSTB;
                ST_WSTB:  state <= ST_WHLD;
                ST_WHLD:  state <= ST_IDLE;
                ST_RSET:  state <= ST_RSTB1;
                ST_RSTB1: state <= ST_RSTB2;
                ST_RSTB2: begin
                    rd_data  <= data_i;
                    rd_valid <= 1'b1;
                    state    <= ST_RHLD;
                end
                ST_RHLD:  state <= ST_IDLE;
                ST_BSET:  state <= ST_BSTB;
                ST_BSTB: begin
                    if (more) begin
                        remain <= remain - 1'b1;
                        addr_q <= addr_q + 1'b1;
                        if (is_blk) data_q <= blk_data;
                        state  <= ST_BSET;
                    end else begin
                        state  <= ST_BEND;
                    end
                end
                ST_BEND:  state <= ST_IDLE;
                ST_PULSE: if (!pulse_active) state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/zbus_master.sv
module zbus_master
    import zbm_pkg::*;
#(
    parameter int              ADDR_W      = 19,
    parameter int              DATA_W      = 8,
    parameter int              LEN_W       = 16,
    parameter int              SYNC_STAGES = 2,
    parameter int              PULSE_DEF   = 48,
    parameter logic [ADDR_W-1:0] UNBUF_MASK = 19'h7C080
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic [LEN_W-1:0]  cmd_len,
    output logic              busy,
    output logic              err,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              blk_take,
    input  logic [DATA_W-1:0] blk_data,
    output logic              bus_owned,
    output logic              busreq_n,
    input  logic              busack_n,
    output logic [ADDR_W-1:0] addr_o,
    output logic [ADDR_W-1:0] addr_oe,
    output logic [DATA_W-1:0] data_o,
    input  logic [DATA_W-1:0] data_i,
    output logic              data_oe,
    output logic              mreq_n,
    output logic              rd_n,
    output logic              wr_n,
    output logic              cpu_rst_n
);
    logic     ack_seen_n;
    logic     pulse_active;
    logic     pulse_start;
    logic     level_set;
    logic     level_val;
    strobes_t strb;

    zbm_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) ack_sync_i (
        .clk (clk),
        .rst (rst),
        .d   (busack_n),
        .q   (ack_seen_n)
    );

    zbm_rst_pulse #(.TICK_W(LEN_W), .DEF_TICKS(PULSE_DEF)) rst_gen_i (
        .clk       (clk),
        .rst       (rst),
        .set_level (level_set),
        .level     (level_val),
        .start     (pulse_start),
        .ticks     (cmd_len),
        .cpu_rst_n (cpu_rst_n),
        .active    (pulse_active)
    );

    zbm_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W)) seq_i (
        .clk          (clk),
        .rst          (rst),
        .cmd_valid    (cmd_valid),
        .cmd_op       (op_e'(cmd_op)),
        .cmd_addr     (cmd_addr),
        .cmd_data     (cmd_data),
        .cmd_len      (cmd_len),
        .data_i       (data_i),
        .blk_data     (blk_data),
        .ack_seen_n   (ack_seen_n),
        .pulse_active (pulse_active),
        .strb         (strb),
        .busreq_n     (busreq_n),
        .owned        (bus_owned),
        .addr_q       (addr_o),
        .data_q       (data_o),
        .busy         (busy),
        .err          (err),
        .rd_valid     (rd_valid),
        .rd_data      (rd_data),
        .blk_take     (blk_take),
        .pulse_start  (pulse_start),
        .level_set    (level_set),
        .level_val    (level_val)
    );

    assign mreq_n  = strb.mreq_n;
    assign rd_n    = strb.rd_n;
    assign wr_n    = strb.wr_n;
    assign data_oe = strb.data_oe;
    assign addr_oe = bus_owned ? {ADDR_W{1'b1}} : ~UNBUF_MASK;
endmodule

// File: rtl/zbm_checks.sv
module zbm_checks (
    input logic clk,
    input logic rst,
    input logic busy,
    input logic err,
    input logic rd_valid,
    input logic bus_owned,
    input logic busreq_n,
    input logic busack_n,
    input logic data_oe,
    input logic mreq_n,
    input logic rd_n,
    input logic wr_n
);
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(!rd_n && !wr_n)); // R12
    AST_STROBE_IN_MREQ: assert property (@(posedge clk) disable iff (rst)
        (!rd_n || !wr_n) |-> !mreq_n); // R12
    AST_NO_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (rst)
        !rd_n |-> !data_oe); // R12
    AST_QUIET_UNOWNED: assert property (@(posedge clk) disable iff (rst)
        !bus_owned |-> (mreq_n && !data_oe)); // R8
    AST_OWNED_HAS_REQ: assert property (@(posedge clk) disable iff (rst)
        bus_owned |-> !busreq_n); // R2
    AST_ACK_BEFORE_OWN: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_owned) |-> ($past(busack_n, 2) == 1'b0)); // R2
    AST_RELEASE_REQ_HIGH: assert property (@(posedge clk) disable iff (rst)
        $fell(bus_owned) |-> busreq_n); // R3
    AST_RDV_SINGLE: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !rd_valid); // R5
    AST_ERR_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
        err |-> !busy); // R8
endmodule

bind zbus_master zbm_checks chk_i (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .err       (err),
    .rd_valid  (rd_valid),
    .bus_owned (bus_owned),
    .busreq_n  (busreq_n),
    .busack_n  (busack_n),
    .data_oe   (data_oe),
    .mreq_n    (mreq_n),
    .rd_n      (rd_n),
    .wr_n      (wr_n)
);

// File: tb/zbus_master_tb.sv
module zbus_master_tb_top;
    localparam logic [18:0] UNBUF = 19'h7C080;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = 3'd0;
    logic [18:0] cmd_addr = '0;
    logic [7:0]  cmd_data = '0;
    logic [15:0] cmd_len = '0;
    logic        busy, err, rd_valid, blk_take, bus_owned, busreq_n;
    logic [7:0]  rd_data, data_o, data_i, blk_data;
    logic [18:0] addr_o, addr_oe;
    logic        data_oe, mreq_n, rd_n, wr_n, cpu_rst_n;
    logic [2:0]  ack_sh = 3'b111;
    logic        busack_n;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    zbus_master dut_i (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cmd_len(cmd_len),
        .busy(busy), .err(err), .rd_valid(rd_valid), .rd_data(rd_data),
        .blk_take(blk_take), .blk_data(blk_data), .bus_owned(bus_owned),
        .busreq_n(busreq_n), .busack_n(busack_n), .addr_o(addr_o),
        .addr_oe(addr_oe), .data_o(data_o), .data_i(data_i),
        .data_oe(data_oe), .mreq_n(mreq_n), .rd_n(rd_n), .wr_n(wr_n),
        .cpu_rst_n(cpu_rst_n)
    );

    // CPU model: acknowledge follows request three clocks later
    always @(posedge clk) ack_sh <= {ack_sh[1:0], busreq_n};
    assign busack_n = ack_sh[2];

    // memory model: only answers while the read strobe is low
    function automatic logic [7:0] mem_at(logic [18:0] a);
        return a[7:0] ^ a[15:8] ^ {5'b10100, a[18:16]};
    endfunction
    assign data_i = !rd_n ? mem_at(addr_o) : 8'h00;

    // block source
    logic [7:0] blk_arr [0:7];
    int bidx = 0;
    assign blk_data = blk_arr[bidx];
    always @(posedge clk) if (blk_take) bidx <= bidx + 1;

    // per-cycle expected pin state
    typedef struct {
        int          req;
        logic        m, r, w, oe, bz, rv, er;
        logic [18:0] a;
        logic [7:0]  d;
        bit          chk_ad;
    } exp_t;
    exp_t exp_q[$];

    function automatic exp_t mk(int req, logic m, logic r, logic w, logic oe,
                                logic bz, logic rv, logic er,
                                logic [18:0] a, logic [7:0] d, bit chk);
        exp_t e;
        e.req = req; e.m = m; e.r = r; e.w = w; e.oe = oe; e.bz = bz;
        e.rv = rv; e.er = er; e.a = a; e.d = d; e.chk_ad = chk;
        return e;
    endfunction

    task automatic check(bit ok, int req, string what, longint act, longint expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL R%0d %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            exp_t e;
            logic [6:0] act, expv;
            e    = exp_q.pop_front();
            act  = {mreq_n, rd_n, wr_n, data_oe, busy, rd_valid, err};
            expv = {e.m, e.r, e.w, e.oe, e.bz, e.rv, e.er};
            check(act == expv, e.req, "strobes/busy/valid/err", act, expv);
            if (e.chk_ad) begin
                check(addr_o == e.a, e.req, "address", addr_o, e.a);
                if (e.oe) check(data_o == e.d, e.req, "data out", data_o, e.d);
            end
            if (e.rv) check(rd_data == e.d, e.req, "read data", rd_data, e.d);
        end
    end

    task automatic drain();
        while (exp_q.size() > 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic issue(logic [2:0] op, logic [18:0] a, logic [7:0] d, logic [15:0] n);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_data = d; cmd_len = n;
    endtask

    task automatic idle_entry(int req);
        exp_q.push_back(mk(req, 1, 1, 1, 0, 0, 0, 0, '0, '0, 0));
    endtask

    // R4 write; optional extra command while busy (R9)
    task automatic do_write(logic [18:0] a, logic [7:0] d, bit poke);
        @(negedge clk);
        issue(3'd2, a, d, 16'd0);
        exp_q.push_back(mk(4, 0, 1, 1, 1, 1, 0, 0, a, d, 1));
        exp_q.push_back(mk(4, 0, 1, 0, 1, 1, 0, 0, a, d, 1));
        exp_q.push_back(mk(4, 0, 1, 1, 1, 1, 0, 0, a, d, 1));
        idle_entry(4);
        if (poke) idle_entry(9);
        @(negedge clk);
        cmd_valid = 1'b0;
        if (poke) begin
            issue(3'd3, a + 19'd1, 8'h00, 16'd0); // R9: must be dropped
            @(negedge clk);
            cmd_valid = 1'b0;
        end
        drain();
    endtask

    // R5 read
    task automatic do_read(logic [18:0] a);
        @(negedge clk);
        issue(3'd3, a, 8'h00, 16'd0);
        exp_q.push_back(mk(5, 0, 1, 1, 0, 1, 0, 0, a, '0, 1));
        exp_q.push_back(mk(5, 0, 0, 1, 0, 1, 0, 0, a, '0, 1));
        exp_q.push_back(mk(5, 0, 0, 1, 0, 1, 0, 0, a, '0, 1));
        exp_q.push_back(mk(5, 0, 1, 1, 0, 1, 1, 0, a, mem_at(a), 1));
        idle_entry(5);
        @(negedge clk);
        cmd_valid = 1'b0;
        drain();
    endtask

    // R6 fill / R7 block
    task automatic do_multi(bit blk, logic [18:0] a, logic [7:0] d, int n);
        int req;
        req = blk ? 7 : 6;
        @(negedge clk);
        issue(blk ? 3'd5 : 3'd4, a, d, 16'(n));
        for (int i = 0; i < n; i++) begin
            logic [7:0] bd;
            bd = blk ? blk_arr[bidx + i] : d;
            exp_q.push_back(mk(req, 0, 1, 1, 1, 1, 0, 0, a + 19'(i), bd, 1));
            exp_q.push_back(mk(req, 0, 1, 0, 1, 1, 0, 0, a + 19'(i), bd, 1));
        end
        exp_q.push_back(mk(req, 0, 1, 1, 1, 1, 0, 0, '0, '0, 0));
        idle_entry(req);
        @(negedge clk);
        cmd_valid = 1'b0;
        drain();
    endtask

    // R8 rejected command
    task automatic do_reject(logic [2:0] op, logic [15:0] n);
        @(negedge clk);
        issue(op, 19'h12345, 8'h77, n);
        exp_q.push_back(mk(8, 1, 1, 1, 0, 0, 0, 1, '0, '0, 0));
        idle_entry(8);
        @(negedge clk);
        cmd_valid = 1'b0;
        drain();
    endtask

    task automatic handshake(bit acq);
        int cyc;
        @(negedge clk);
        issue(acq ? 3'd0 : 3'd1, '0, '0, '0);
        @(negedge clk);
        cmd_valid = 1'b0;
        if (acq) begin
            check(busreq_n == 1'b0, 2, "busreq_n after acquire", busreq_n, 0);
            check(bus_owned == 1'b0 && busy, 2, "not yet owned", {bus_owned, busy}, 1);
        end else begin
            check(busreq_n && !bus_owned && !data_oe, 3, "release pins",
                  {busreq_n, bus_owned, data_oe}, 3'b100);
            check(addr_oe == ~UNBUF, 3, "unbuffered bits tristated", addr_oe, ~UNBUF);
        end
        cyc = 1;
        while (busy) begin @(negedge clk); cyc++; end
        check(cyc == 7, acq ? 2 : 3, "handshake cycles incl. idle", cyc, 7);
        if (acq) begin
            check(bus_owned && addr_oe == '1, 2, "owned, all address drivers",
                  {bus_owned, addr_oe}, {1'b1, 19'h7FFFF});
        end else begin
            check(busack_n == 1'b1 && !bus_owned, 3, "ack high after release",
                  busack_n, 1);
        end
    endtask

    task automatic do_pulse(logic [15:0] n, int expect_low);
        int low;
        @(negedge clk);
        issue(3'd7, '0, '0, n);
        @(negedge clk);
        cmd_valid = 1'b0;
        low = 0;
        while (cpu_rst_n == 1'b0) begin low++; @(negedge clk); end
        check(low == expect_low, 11, "reset pulse length", low, expect_low);
        while (busy) @(negedge clk);
        check(cpu_rst_n == 1'b1, 11, "reset high after pulse", cpu_rst_n, 1);
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) blk_arr[i] = 8'(8'h3C + 8'(i * 29));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check({busreq_n, mreq_n, rd_n, wr_n, cpu_rst_n} == 5'h1F, 1, "idle strobes",
              {busreq_n, mreq_n, rd_n, wr_n, cpu_rst_n}, 5'h1F);
        check({data_oe, busy, err, rd_valid, bus_owned} == 5'h0, 1, "idle flags",
              {data_oe, busy, err, rd_valid, bus_owned}, 0);
        check(addr_oe == ~UNBUF, 1, "address enables", addr_oe, ~UNBUF);

        do_reject(3'd3, 16'd0);   // R8: read before owning
        do_reject(3'd4, 16'd4);   // R8: fill before owning
        handshake(1'b1);          // R2
        do_write(19'h4ABCD, 8'h5A, 1'b0);
        do_write(19'h00080, 8'hC3, 1'b1); // R9 poke while busy
        do_read(19'h7C081);
        do_read(19'h12345);
        do_multi(1'b0, 19'h0FFFE, 8'hE7, 3);  // R6 crosses bit 16
        do_multi(1'b0, 19'h00100, 8'h11, 1);  // R6 single byte
        do_multi(1'b1, 19'h20000, 8'h00, 4);  // R7
        check(bidx == 4, 7, "block bytes taken", bidx, 4);
        do_reject(3'd5, 16'd0);   // R8: zero-length block
        check(bidx == 4, 8, "no byte taken on reject", bidx, 4);
        handshake(1'b0);          // R3
        do_reject(3'd2, 16'd0);   // R8: write after release

        // R10 reset level
        @(negedge clk); issue(3'd6, '0, 8'h00, '0);
        @(negedge clk); cmd_valid = 1'b0;
        check(cpu_rst_n == 1'b0 && !busy, 10, "reset forced low", {cpu_rst_n, busy}, 0);
        @(negedge clk); issue(3'd6, '0, 8'h01, '0);
        @(negedge clk); cmd_valid = 1'b0;
        check(cpu_rst_n == 1'b1 && !busy, 10, "reset forced high", {cpu_rst_n, busy}, 2);

        do_pulse(16'd5, 5);    // R11
        do_pulse(16'd1, 1);    // R11 shortest
        do_pulse(16'd0, 48);   // R11 default

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule